// File: doc/BRIEF.md
# Per-Link Stream Reservation Manager

This block is the resource manager for time-paced streams leaving a bridge on one output link. It takes already decoded control messages, either a join (stream identifier, requested bytes per cycle, accumulated path delay) or a leave (stream identifier). It holds a small table of admitted streams, each with its reserved bandwidth and listener count, and a running sum of the bandwidth committed against a configured per-cycle link budget. For every message it gives back, one clock later, a decision: pass the message on toward the talker, or answer it locally. It also returns an unavailable flag and an updated delay value.

A second job runs alongside. Each admitted stream must show at least one talker packet per cycle, and a zero-length packet counts. A cycle strobe advances a silence counter for every admitted stream. A packet-seen pulse, tagged with a stream identifier, clears the counter of that stream. A stream that stays silent too long is removed, its bandwidth goes back to the free budget, and a teardown pulse names it.

Top module: `stream_rsv_mgr`

## Requirements
- R1: After reset `rsp_valid` and `td_valid` are low, the table is empty and the whole of `cfg_budget` is free.
- R2: Every message with `msg_valid` high gets exactly one response with `rsp_valid` high on the next clock, carrying the same `rsp_stream_id`. No response appears without a message.
- R3: A join (`msg_leave`=0) for a stream not in the table, with a free table slot and with `msg_bw` no larger than the remaining budget, reserves the bandwidth. The response has `rsp_forward`=1, `rsp_unavail`=0 and `rsp_delay` = `msg_delay` + `cfg_hop_delay`, saturating at the all-ones value. An exact fit succeeds.
- R4: A join for a new stream whose `msg_bw` exceeds the remaining budget reserves nothing. The response has `rsp_forward`=1, `rsp_unavail`=1 and `rsp_delay` = `msg_delay`.
- R5: A join for a new stream while every table slot is in use is handled like R4, even when its bandwidth would fit.
- R6: A join for a stream already in the table is answered locally. The response has `rsp_forward`=0, `rsp_unavail`=0 and `rsp_delay` = `msg_delay` + `cfg_hop_delay`. The listener count rises by one and no bandwidth is added. At the maximum count the join is answered locally with `rsp_unavail`=1 instead.
- R7: A leave (`msg_leave`=1) for a stream with more than one listener is absorbed (`rsp_forward`=0, `rsp_unavail`=0). It only lowers the listener count.
- R8: A leave that removes the last listener is forwarded (`rsp_forward`=1, `rsp_unavail`=0). The slot and the bandwidth are freed together, so a join on the next clock can use both.
- R9: A leave for a stream not in the table is forwarded with `rsp_unavail`=1 and changes nothing. Every leave response carries `rsp_delay` = `msg_delay`.
- R10: A stream that sees no `pkt_seen` with its identifier across more than `cfg_silence_limit` consecutive `cycle_tick` strobes is removed. `td_valid` pulses with `td_stream_id` on the clock after the expiring strobe, and its bandwidth returns to the budget. A `pkt_seen` restarts the count, and a `pkt_seen` that comes in the same clock as the strobe counts as a packet for that cycle.
- R11: When several streams expire together, one teardown is reported per clock, lowest table slot first (slots fill lowest free index first).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_budget | input | BUD_W | Per-cycle link budget in bytes |
| cfg_hop_delay | input | DLY_W | Delay this bridge adds to a granted request |
| cfg_silence_limit | input | CNT_W | Silent cycles allowed before teardown |
| msg_valid | input | 1 | A decoded control message is present |
| msg_leave | input | 1 | 1 = leave, 0 = join |
| msg_stream_id | input | ID_W | Stream identifier of the message |
| msg_bw | input | BW_W | Requested bytes per cycle (join only) |
| msg_delay | input | DLY_W | Accumulated delay count in the message |
| cycle_tick | input | 1 | One-clock strobe per cycle |
| pkt_seen | input | 1 | A talker packet was seen |
| pkt_stream_id | input | ID_W | Stream of the seen packet |
| rsp_valid | output | 1 | Decision valid |
| rsp_stream_id | output | ID_W | Stream of the decision |
| rsp_forward | output | 1 | 1 = pass toward talker, 0 = answered here |
| rsp_unavail | output | 1 | Resources not granted or stream unknown |
| rsp_delay | output | DLY_W | Updated delay count |
| td_valid | output | 1 | Stream torn down for silence |
| td_stream_id | output | ID_W | Stream that was torn down |

## Verification
The hardest state to reach from the ports is a silence counter sitting exactly at its limit while a neighbouring stream is kept alive. Two expiries landing on the same strobe is just as hard to reach. The stimulus admits two streams and feeds packets for one of them on every strobe. It gives the other a single packet between strobes so that its count restarts, then brings it to the limit and one past it. A separate run admits two streams, lets both go silent, and watches the teardown queue drain in slot order across successive clocks.

// File: rtl/stream_rsv_pkg.sv
package stream_rsv_pkg;

    typedef enum logic {
        KIND_JOIN  = 1'b0,
        KIND_LEAVE = 1'b1
    } msg_kind_e;

endpackage

// File: rtl/rsv_pick_first.sv
module rsv_pick_first #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rsv_silence_timer.sv
module rsv_silence_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             arm,
    input  logic             tick,
    input  logic             seen,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             exp;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!active || arm) begin
            tmr_d = '0;
        end else if (seen) begin
            tmr_d.cnt = '0;
        end else if (tick && !tmr_q.exp) begin
            if (tmr_q.cnt >= limit) tmr_d.exp = 1'b1;
            else                    tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired = tmr_q.exp;

    // R10: expiry is only raised by an unanswered cycle strobe
    p_expire_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_q.exp) |-> $past(tick && !seen && active));
endmodule

// File: rtl/stream_rsv_mgr.sv
module stream_rsv_mgr
    import stream_rsv_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter int ID_W    = 8,
    parameter int BW_W    = 12,
    parameter int BUD_W   = 16,
    parameter int DLY_W   = 16,
    parameter int LC_W    = 4,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUD_W-1:0] cfg_budget,
    input  logic [DLY_W-1:0] cfg_hop_delay,
    input  logic [CNT_W-1:0] cfg_silence_limit,
    input  logic             msg_valid,
    input  logic             msg_leave,
    input  logic [ID_W-1:0]  msg_stream_id,
    input  logic [BW_W-1:0]  msg_bw,
    input  logic [DLY_W-1:0] msg_delay,
    input  logic             cycle_tick,
    input  logic             pkt_seen,
    input  logic [ID_W-1:0]  pkt_stream_id,
    output logic             rsp_valid,
    output logic [ID_W-1:0]  rsp_stream_id,
    output logic             rsp_forward,
    output logic             rsp_unavail,
    output logic [DLY_W-1:0] rsp_delay,
    output logic             td_valid,
    output logic [ID_W-1:0]  td_stream_id
);
    localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
    localparam logic [LC_W-1:0] LC_MAX = {LC_W{1'b1}};

    typedef struct packed {
        logic             valid;
        logic [ID_W-1:0]  id;
        logic [BW_W-1:0]  bw;
        logic [LC_W-1:0]  lcnt;
    } entry_t;

    typedef struct packed {
        entry_t [N_SLOTS-1:0] tbl;
        logic [BUD_W-1:0]     used;
        logic                 rsp_valid;
        logic [ID_W-1:0]      rsp_id;
        logic                 rsp_fwd;
        logic                 rsp_unav;
        logic [DLY_W-1:0]     rsp_dly;
        logic                 td_valid;
        logic [ID_W-1:0]      td_id;
    } state_t;

    state_t st_d, st_q;

    logic [N_SLOTS-1:0] valid_vec, exp_vec, hit_vec, free_vec, arm_vec;
    logic               exp_found, hit_found, free_found;
    logic [SLOT_W-1:0]  exp_idx, hit_idx, free_idx;
    msg_kind_e          kind;
    logic [DLY_W:0]     dly_sum;
    logic [DLY_W-1:0]   dly_hop;
    logic [BUD_W:0]     need;

    assign kind    = msg_leave ? KIND_LEAVE : KIND_JOIN;
    assign dly_sum = {1'b0, msg_delay} + {1'b0, cfg_hop_delay};
    assign dly_hop = dly_sum[DLY_W] ? {DLY_W{1'b1}} : dly_sum[DLY_W-1:0];

    // per-slot silence supervision; slot in teardown counts as free, not as a hit
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        assign valid_vec[g] = st_q.tbl[g].valid;
        assign hit_vec[g]   = st_q.tbl[g].valid && (st_q.tbl[g].id == msg_stream_id)
                              && !(exp_found && exp_idx == SLOT_W'(g));
        assign free_vec[g]  = !st_q.tbl[g].valid || (exp_found && exp_idx == SLOT_W'(g));

        rsv_silence_timer #(.CNT_W(CNT_W)) tmr_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (st_q.tbl[g].valid),
            .arm     (arm_vec[g]),
            .tick    (cycle_tick),
            .seen    (pkt_seen && (pkt_stream_id == st_q.tbl[g].id)),
            .limit   (cfg_silence_limit),
            .expired (exp_vec[g])
        );
    end

    rsv_pick_first #(.N(N_SLOTS), .IW(SLOT_W)) pick_exp_i (
        .req(exp_vec & valid_vec), .found(exp_found), .idx(exp_idx));
    rsv_pick_first #(.N(N_SLOTS), .IW(SLOT_W)) pick_hit_i (
        .req(hit_vec), .found(hit_found), .idx(hit_idx));
    rsv_pick_first #(.N(N_SLOTS), .IW(SLOT_W)) pick_free_i (
        .req(free_vec), .found(free_found), .idx(free_idx));

    always_comb begin
        st_d          = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.td_valid  = 1'b0;
        arm_vec        = '0;
        need           = '0;

        if (exp_found) begin
            st_d.used                = st_d.used - BUD_W'(st_q.tbl[exp_idx].bw);
            st_d.tbl[exp_idx].valid  = 1'b0;
            st_d.td_valid            = 1'b1;
            st_d.td_id               = st_q.tbl[exp_idx].id;
        end

        if (msg_valid) begin
            st_d.rsp_valid = 1'b1;
            st_d.rsp_id    = msg_stream_id;
            st_d.rsp_fwd   = 1'b1;
            st_d.rsp_unav  = 1'b0;
            st_d.rsp_dly   = msg_delay;
            if (kind == KIND_LEAVE) begin
                if (!hit_found) begin
                    st_d.rsp_unav = 1'b1;
                end else if (st_q.tbl[hit_idx].lcnt > LC_W'(1)) begin
                    st_d.tbl[hit_idx].lcnt = st_q.tbl[hit_idx].lcnt - 1'b1;
                    st_d.rsp_fwd           = 1'b0;
                end else begin
                    st_d.tbl[hit_idx].valid = 1'b0;
                    st_d.used = st_d.used - BUD_W'(st_q.tbl[hit_idx].bw);
                end
            end else begin
                need = {1'b0, st_d.used} + (BUD_W + 1)'(msg_bw);
                if (hit_found) begin
                    st_d.rsp_fwd = 1'b0;
                    if (st_q.tbl[hit_idx].lcnt == LC_MAX) begin
                        st_d.rsp_unav = 1'b1;
                    end else begin
                        st_d.tbl[hit_idx].lcnt = st_q.tbl[hit_idx].lcnt + 1'b1;
                        st_d.rsp_dly           = dly_hop;
                    end
                end else if (free_found && need <= {1'b0, cfg_budget}) begin
                    st_d.tbl[free_idx].valid = 1'b1;
                    st_d.tbl[free_idx].id    = msg_stream_id;
                    st_d.tbl[free_idx].bw    = msg_bw;
                    st_d.tbl[free_idx].lcnt  = LC_W'(1);
                    st_d.used                = need[BUD_W-1:0];
                    st_d.rsp_dly             = dly_hop;
                    arm_vec[free_idx]        = 1'b1;
                end else begin
                    st_d.rsp_unav = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid     = st_q.rsp_valid;
    assign rsp_stream_id = st_q.rsp_id;
    assign rsp_forward   = st_q.rsp_fwd;
    assign rsp_unavail   = st_q.rsp_unav;
    assign rsp_delay     = st_q.rsp_dly;
    assign td_valid      = st_q.td_valid;
    assign td_stream_id  = st_q.td_id;

    p_rsp_follows_msg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> rsp_valid && rsp_stream_id == $past(msg_stream_id));
    p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid |=> !rsp_valid);
    p_unavail_holds_budget_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_unavail |-> st_q.used <= $past(st_q.used));
    p_local_holds_budget_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_forward |-> st_q.used <= $past(st_q.used));
    p_last_leave_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_forward && !rsp_unavail && $past(msg_leave)
        |-> $countones(valid_vec) < $past($countones(valid_vec)));
    p_td_needs_expiry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        td_valid |-> $past(|(exp_vec & valid_vec)));
endmodule

// File: tb/stream_rsv_mgr_tb_top.sv
module stream_rsv_mgr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ID_W = 8, BW_W = 12, BUD_W = 16, DLY_W = 16, CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [BUD_W-1:0] cfg_budget = 16'd100;
    logic [DLY_W-1:0] cfg_hop_delay = 16'd5;
    logic [CNT_W-1:0] cfg_silence_limit = 8'd3;
    logic             msg_valid = 1'b0, msg_leave = 1'b0;
    logic [ID_W-1:0]  msg_stream_id = '0;
    logic [BW_W-1:0]  msg_bw = '0;
    logic [DLY_W-1:0] msg_delay = '0;
    logic             cycle_tick = 1'b0, pkt_seen = 1'b0;
    logic [ID_W-1:0]  pkt_stream_id = '0;
    logic             rsp_valid, rsp_forward, rsp_unavail, td_valid;
    logic [ID_W-1:0]  rsp_stream_id, td_stream_id;
    logic [DLY_W-1:0] rsp_delay;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stream_rsv_mgr dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_budget(cfg_budget), .cfg_hop_delay(cfg_hop_delay),
        .cfg_silence_limit(cfg_silence_limit), .msg_valid(msg_valid), .msg_leave(msg_leave),
        .msg_stream_id(msg_stream_id), .msg_bw(msg_bw), .msg_delay(msg_delay),
        .cycle_tick(cycle_tick), .pkt_seen(pkt_seen), .pkt_stream_id(pkt_stream_id),
        .rsp_valid(rsp_valid), .rsp_stream_id(rsp_stream_id), .rsp_forward(rsp_forward),
        .rsp_unavail(rsp_unavail), .rsp_delay(rsp_delay), .td_valid(td_valid),
        .td_stream_id(td_stream_id)
    );

    typedef struct packed {
        logic        leave;
        logic [7:0]  id;
        logic [11:0] bw;
        logic [15:0] dly;
        logic        fwd;
        logic        unav;
        logic [15:0] odly;
    } vec_t;

    // budget 100, hop 5, four slots
    localparam vec_t VECS [12] = '{
        '{1'b0, 8'd1, 12'd40, 16'd10, 1'b1, 1'b0, 16'd15},  // R3 new stream fits
        '{1'b0, 8'd2, 12'd50, 16'd0,  1'b1, 1'b0, 16'd5},   // R3
        '{1'b0, 8'd3, 12'd20, 16'd7,  1'b1, 1'b1, 16'd7},   // R4 shortfall
        '{1'b0, 8'd3, 12'd10, 16'd7,  1'b1, 1'b0, 16'd12},  // R3 exact fit
        '{1'b0, 8'd1, 12'd40, 16'd3,  1'b0, 1'b0, 16'd8},   // R6 known stream
        '{1'b0, 8'd4, 12'd0,  16'd1,  1'b1, 1'b0, 16'd6},   // R3 zero bw
        '{1'b0, 8'd5, 12'd0,  16'd2,  1'b1, 1'b1, 16'd2},   // R5 table full
        '{1'b1, 8'd1, 12'd0,  16'd0,  1'b0, 1'b0, 16'd0},   // R7 absorbed
        '{1'b1, 8'd1, 12'd0,  16'd9,  1'b1, 1'b0, 16'd9},   // R8 last listener
        '{1'b0, 8'd5, 12'd40, 16'd2,  1'b1, 1'b0, 16'd7},   // R8 freed slot and bw reused
        '{1'b1, 8'd9, 12'd0,  16'd4,  1'b1, 1'b1, 16'd4},   // R9 unknown leave
        '{1'b0, 8'd6, 12'd1,  16'd0,  1'b1, 1'b1, 16'd0}    // R5 full again
    };

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send(input logic lv, input logic [7:0] id, input logic [11:0] bw,
                        input logic [15:0] dly);
        msg_valid = 1'b1; msg_leave = lv; msg_stream_id = id; msg_bw = bw; msg_delay = dly;
        step();
        msg_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic tick_with(input logic see, input logic [7:0] id);
        cycle_tick = 1'b1; pkt_seen = see; pkt_stream_id = id;
        step();
        cycle_tick = 1'b0; pkt_seen = 1'b0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1", "rsp_valid after reset", 32'(rsp_valid), 0);
        chk("R1", "td_valid after reset", 32'(td_valid), 0);

        for (int v = 0; v < 12; v++) begin
            send(VECS[v].leave, VECS[v].id, VECS[v].bw, VECS[v].dly);
            chk("R2", $sformatf("vec%0d rsp_valid", v), 32'(rsp_valid), 1);
            chk("R2", $sformatf("vec%0d id", v), 32'(rsp_stream_id), 32'(VECS[v].id));
            chk("R3-R9", $sformatf("vec%0d forward", v), 32'(rsp_forward), 32'(VECS[v].fwd));
            chk("R3-R9", $sformatf("vec%0d unavail", v), 32'(rsp_unavail), 32'(VECS[v].unav));
            chk("R3-R9", $sformatf("vec%0d delay", v), 32'(rsp_delay), 32'(VECS[v].odly));
        end
        step();
        chk("R2", "no response when idle", 32'(rsp_valid), 0);

        // R1: full budget free after a fresh reset
        do_reset();
        send(1'b0, 8'd7, 12'd100, 16'd0);
        chk("R1", "whole budget free", 32'(rsp_unavail), 0);

        // R3 delay saturation
        send(1'b0, 8'd8, 12'd0, 16'hFFFE);
        chk("R3", "saturated delay", 32'(rsp_delay), 32'hFFFF);

        // R10 silence supervision, limit 3
        do_reset();
        send(1'b0, 8'd1, 12'd10, 16'd0);
        send(1'b0, 8'd2, 12'd10, 16'd0);
        tick_with(1'b1, 8'd1);
        tick_with(1'b1, 8'd1);
        pkt_seen = 1'b1; pkt_stream_id = 8'd2;
        step();
        pkt_seen = 1'b0;
        for (int t = 0; t < 3; t++) begin
            tick_with(1'b1, 8'd1);
            chk("R10", $sformatf("no early teardown t%0d", t), 32'(td_valid), 0);
        end
        tick_with(1'b1, 8'd1);
        chk("R10", "no teardown on expiring clock", 32'(td_valid), 0);
        step();
        chk("R10", "teardown pulse", 32'(td_valid), 1);
        chk("R10", "teardown id", 32'(td_stream_id), 2);
        step();
        chk("R10", "teardown single pulse", 32'(td_valid), 0);
        send(1'b0, 8'd3, 12'd90, 16'd0);
        chk("R10", "bandwidth returned", 32'(rsp_unavail), 0);
        send(1'b0, 8'd2, 12'd0, 16'd0);
        chk("R10", "torn stream is new again", 32'(rsp_forward), 1);

        // R11 simultaneous expiry, drained lowest slot first
        do_reset();
        send(1'b0, 8'd11, 12'd5, 16'd0);
        send(1'b0, 8'd12, 12'd5, 16'd0);
        for (int t = 0; t < 4; t++) tick_with(1'b0, 8'd0);
        step();
        chk("R11", "first teardown valid", 32'(td_valid), 1);
        chk("R11", "first teardown id", 32'(td_stream_id), 11);
        step();
        chk("R11", "second teardown valid", 32'(td_valid), 1);
        chk("R11", "second teardown id", 32'(td_stream_id), 12);
        step();
        chk("R11", "queue drained", 32'(td_valid), 0);

        done = 1'b1;
        report();
    end
endmodule